// File: doc/BRIEF.md
# Run-time Adjustable Serial Delay Line

This block is a one-bit shift register whose read point can be moved while it runs. On every active clock edge where shifting is allowed, the serial input enters stage 0 and every stage passes its bit one place further along the chain. A tap-select input picks one stage and drives it onto the single-bit output. The block therefore behaves as a delay line whose length, from one to DEPTH enabled edges, is set at run time.

The stage count is a parameter of at least 3. The tap select is ceil(log2(DEPTH)) bits wide. Three further parameters set the design-time options:
- which clock edge is active (EDGE_RISE);
- how the enable is read (EN_MODE: active-high, active-low, or ignored);
- the power-up contents of every stage (INIT_BITS).

There is no reset. A stage whose power-up bit is left undefined starts unknown. A tap value at or above DEPTH drives an unknown output.

Top module: `vtap_shreg`

## Requirements
- R1: Before any active edge, stage i holds bit i of INIT_BITS, so `dout` with `tap` = i equals INIT_BITS[i].
- R2: With EDGE_RISE = 1 the stages change only on rising edges of `clk`; with EDGE_RISE = 0 they change only on falling edges.
- R3: With EN_MODE = 1, an active edge shifts only when `en` is 1.
- R4: With EN_MODE = 0, an active edge shifts only when `en` is 0.
- R5: With EN_MODE = 2, every active edge shifts, whatever the value of `en`.
- R6: An active edge with the enable inactive leaves every stage unchanged, so `dout` at every tap value keeps its value.
- R7: `tap` = L (L < DEPTH) returns the `din` bit captured L+1 shifting edges earlier: tap 0 is the newest bit and tap DEPTH-1 is the oldest.
- R8: `dout` follows `tap` combinationally, so a new tap value is reflected on `dout` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is set by EDGE_RISE |
| en | input | 1 | Shift enable; its polarity, or whether it is used at all, is set by EN_MODE |
| din | input | 1 | Serial data entering stage 0 |
| tap | input | $clog2(DEPTH) | Index of the stage driven onto `dout` |
| dout | output | 1 | Bit held in the selected stage |

## Verification
The bench builds six instances, each with DEPTH = 5 and INIT_BITS = 5'b10110. Together they cover both active clock edges and all three enable modes, all driven by one shared stimulus.

The depth is not a power of two. With DEPTH = 5, every legal tap value can be swept combinationally after every clock edge, both active and inactive, against a queue model that updates only on the edge the instance uses. That sweep exposes shifting on the wrong edge, a wrong enable polarity, a missed hold, an off-by-one tap, and an incorrect power-up value.

// File: rtl/vtap_shreg.sv
`timescale 1ns/1ps
module vtap_shreg #(
  parameter int DEPTH = 16,
  parameter bit EDGE_RISE = 1'b1,
  parameter int EN_MODE = 1,
  parameter logic [DEPTH-1:0] INIT_BITS = {DEPTH{1'bx}},
  localparam int SELW = $clog2(DEPTH),
  localparam int IDXW = SELW + 1
) (
  input  logic            clk,
  input  logic            en,
  input  logic            din,
  input  logic [SELW-1:0] tap,
  output logic            dout
);

  logic [DEPTH-1:0] stages = INIT_BITS;
  logic             armed = 1'b0;
  logic             shift_ok;
  logic             in_range;

  assign shift_ok = (EN_MODE == 2) ? 1'b1 : ((EN_MODE == 1) ? en : ~en);
  assign in_range = {1'b0, tap} < IDXW'(DEPTH);
  assign dout     = in_range ? stages[tap] : 1'bx;

  if (EDGE_RISE) begin : g_rise
    always_ff @(posedge clk) begin
      armed <= 1'b1;
      if (shift_ok) stages <= {stages[DEPTH-2:0], din};
    end
  end else begin : g_fall
    always_ff @(negedge clk) begin
      armed <= 1'b1;
      if (shift_ok) stages <= {stages[DEPTH-2:0], din};
    end
  end

  logic aclk;
  assign aclk = EDGE_RISE ? clk : ~clk;

  AST_NEWEST_BIT: assert property (@(posedge aclk) disable iff (!armed)
    $past(shift_ok) |-> stages[0] == $past(din)) else $error("stage 0 missed din"); // R7

  AST_CHAIN_MOVE: assert property (@(posedge aclk) disable iff (!armed)
    $past(shift_ok) |-> stages[DEPTH-1:1] == $past(stages[DEPTH-2:0])) else $error("chain did not advance"); // R7

  AST_HOLD_IDLE: assert property (@(posedge aclk) disable iff (!armed)
    !$past(shift_ok) |-> $stable(stages)) else $error("stages moved while idle"); // R6

  AST_TAP0_DELAY: assert property (@(posedge aclk) disable iff (!armed)
    ($past(shift_ok) && tap == '0) |-> dout == $past(din)) else $error("tap 0 delay wrong"); // R7

  AST_FREE_RUN: assert property (@(posedge aclk) disable iff (!armed)
    (EN_MODE == 2) |-> stages[0] == $past(din)) else $error("free-running mode held"); // R5

endmodule

// File: tb/test_vtap_shreg.sv
`timescale 1ns/100ps
module test_vtap_shreg;
  localparam int D = 5;
  localparam logic [D-1:0] IV = 5'b10110;

  logic clk = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  for (genvar k = 0; k < 6; k++) begin : g_cfg
    localparam bit CP = (k % 2) == 1;
    localparam int EP = k / 2;
    logic [2:0] tp = 3'd0;
    logic dq;
    logic [D-1:0] mdl = IV;
    logic busy = 1'b0;

    vtap_shreg #(.DEPTH(D), .EDGE_RISE(CP), .EN_MODE(EP), .INIT_BITS(IV)) i_vtap_shreg (
      .clk(clk), .en(en), .din(din), .tap(tp), .dout(dq));

    function automatic bit act_en(input logic e);
      return (EP == 2) ? 1'b1 : ((EP == 1) ? e : !e);
    endfunction

    if (CP) begin : g_mr
      always @(posedge clk) if (act_en(en)) mdl <= {mdl[D-2:0], din};
    end else begin : g_mf
      always @(negedge clk) if (act_en(en)) mdl <= {mdl[D-2:0], din};
    end

    task automatic sweep(input string tag);
      busy = 1'b1;
      for (int l = 0; l < D; l++) begin
        tp = 3'(l);
        #0.2;
        n_cmp++;
        if (dq !== mdl[l]) begin
          n_bad++;
          $display("FAIL %s cfg%0d cp=%0d ep=%0d tap=%0d t=%0t got %b exp %b",
                   tag, k, CP, EP, l, $time, dq, mdl[l]);
        end
      end
      busy = 1'b0;
    endtask

    initial begin
      #0.5;
      sweep("R1/R8");
    end

    always @(clk) begin
      string tag;
      if (clk !== CP) tag = "R2";
      else if (!act_en(en)) tag = "R6";
      else if (EP == 1) tag = "R3/R7";
      else if (EP == 0) tag = "R4/R7";
      else tag = "R5/R7";
      #0.5;
      if (!finished) sweep(tag);
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] lf = 8'hA5;
    #2;
    for (int c = 0; c < 240; c++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      din = lf[0];
      en = (c % 11 < 6) ? lf[2] | lf[1] : lf[3] & lf[6];
      #8;
    end
    #3;
    summary();
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired at %0t got running exp finished", $time);
    summary();
  end
endmodule